// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block sequences the track/hold and conversion phases of a successive-approximation ADC. A 3-bit source select picks what starts a conversion. The choices are one of three timer outputs, a control pin used as is or inverted, a free-running continuous mode, or a software start strike. The sequencer drives the track/hold line and enables the converter's power. It also marks the fixed-length conversion phase and reports busy and done to the host logic. The converter itself and its bit search are outside the block, and the conversion is modelled as a timed phase.

Two trigger styles exist for the external sources. In dual-edge mode, one edge of the chosen line opens tracking and the opposite edge closes it, so the user sets the acquisition time. In single-edge mode, one edge opens an internally timed track phase. The length of that phase depends on whether the converter is powered down between conversions. Asynchronous trigger lines are synchronized before their edges are detected. Everything runs on the ADC clock.

Top module: `adcTrigSeq`

## Requirements
- R1: Source select values: 3'b000 timer 0, 3'b001 timer 1, 3'b010 timer 2, 3'b100 control pin, 3'b101 inverted control pin, 3'b110 continuous, 3'b111 software start; lines that are not selected (and code 3'b011) have no effect.
- R2: With dualEdge=1 and a timer or the control pin selected, a rising edge sets trackOn=1 and the next falling edge sets trackOn=0 and starts the conversion, so track lasts as many cycles as the line stayed high.
- R3: With dualEdge=1 and the inverted control pin selected, a falling edge of ctlIn starts tracking and the next rising edge starts the conversion.
- R4: With dualEdge=0, a falling edge of the selected timer or control pin starts a conversion, or a rising edge of ctlIn for the inverted-pin source; the opposite edge has no effect.
- R5: An internally timed start (single-edge or software) holds trackOn=1 for exactly 11 cycles when autoShutdown=1; when autoShutdown=0 the conversion begins at once with trackOn never raised.
- R6: convActive is high for exactly 13 consecutive cycles per conversion, with trackOn low.
- R7: With source 3'b110 and autoShutdown=1 the block first spends 8 cycles powering up, then tracks for 3 cycles and converts for 13, repeating so that done pulses every 16 cycles; with autoShutdown=0 the power-up wait is skipped.
- R8: A one-cycle startWr with source 3'b111 starts an internally timed conversion whatever dualEdge is; startWr with any other source has no effect.
- R9: busy is high from the cycle after the trigger is taken until the last conversion cycle; done is high for exactly one cycle, the cycle after the last conversion cycle.
- R10: Trigger edges and startWr arriving while busy (other than the closing edge of a dual-edge track) are ignored.
- R11: A level change on an asynchronous trigger line takes effect on busy after the third rising clock edge following the change.
- R12: pwrEn equals busy when autoShutdown=1 and is held at 1 when autoShutdown=0.
- R13: Changing the source away from 3'b110 during continuous operation lets the conversion in progress finish, give its done pulse, and then leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcSel | input | 3 | Conversion source select |
| dualEdge | input | 1 | 1 = dual-edge trigger style, 0 = single-edge |
| autoShutdown | input | 1 | Converter powers down between conversions |
| tmrIn | input | NUM_TMR | Asynchronous timer trigger lines |
| ctlIn | input | 1 | Asynchronous control-pin trigger line |
| startWr | input | 1 | One-cycle software start strike |
| pwrEn | output | 1 | Converter power enable |
| trackOn | output | 1 | 1 = track, 0 = hold |
| convActive | output | 1 | High during the conversion phase |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The bench builds the block with its default parameters: three timer lines, two synchronizer stages and the phase lengths 8, 3, 11 and 13. With these values every timed phase fits in a few dozen cycles. The bench can therefore measure each phase length directly and watch several back-to-back continuous conversions. The three-cycle trigger latency is also short enough to check exactly at the edge where busy rises.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;
  localparam logic [2:0] SRC_TMR0 = 3'b000;
  localparam logic [2:0] SRC_TMR1 = 3'b001;
  localparam logic [2:0] SRC_TMR2 = 3'b010;
  localparam logic [2:0] SRC_PIN  = 3'b100;
  localparam logic [2:0] SRC_PINN = 3'b101;
  localparam logic [2:0] SRC_CONT = 3'b110;
  localparam logic [2:0] SRC_SWST = 3'b111;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PWR, PH_TRK, PH_USR, PH_CNV
  } phase_t;

  typedef enum logic [1:0] {
    LEN_PWR, LEN_ACQ, LEN_TRK, LEN_CNV
  } lenSel_t;

  typedef struct packed {
    logic    load;
    lenSel_t len;
  } ctrlStb_t;
endpackage

// File: rtl/adcSeqSync.sv
module adcSeqSync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stg[g] <= '0;
          else       stg[g] <= din;
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stg[g] <= '0;
          else       stg[g] <= stg[g-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/adcSeqPath.sv
module adcSeqPath
  import adcSeqPkg::*;
#(
  parameter int NUM_TMR     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_LEN     = 8,
  parameter int ACQ_LEN     = 3,
  parameter int TRK_LEN     = 11,
  parameter int CONV_LEN    = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_TMR-1:0] tmrIn,
  input  logic               ctlIn,
  input  logic [2:0]         srcSel,
  input  logic               dualEdge,
  input  ctrlStb_t           stb,
  output logic               startEdge,
  output logic               endEdge,
  output logic               cntZero
);
  localparam int LINES   = NUM_TMR + 1;
  localparam int MAX_A   = (PWR_LEN > ACQ_LEN) ? PWR_LEN : ACQ_LEN;
  localparam int MAX_B   = (TRK_LEN > CONV_LEN) ? TRK_LEN : CONV_LEN;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  logic [LINES-1:0] lineSync, linePrev, lineRise, lineFall;
  logic             selRise, selFall, isExt, isInv;
  logic [CNT_W-1:0] cnt, lenVal;

  adcSeqSync #(.W(LINES), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .din({ctlIn, tmrIn}), .dout(lineSync)
  );

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) linePrev <= '0;
    else       linePrev <= lineSync;

  assign lineRise = lineSync & ~linePrev;
  assign lineFall = ~lineSync & linePrev;

  always_comb begin
    selRise = 1'b0;
    selFall = 1'b0;
    isExt   = 1'b0;
    isInv   = 1'b0;
    if (!srcSel[2] && (int'(srcSel[1:0]) < NUM_TMR)) begin
      isExt   = 1'b1;
      selRise = lineRise[srcSel[1:0]];
      selFall = lineFall[srcSel[1:0]];
    end else if (srcSel == SRC_PIN || srcSel == SRC_PINN) begin
      isExt   = 1'b1;
      isInv   = srcSel[0];
      selRise = lineRise[NUM_TMR];
      selFall = lineFall[NUM_TMR];
    end
  end

  assign startEdge = isExt & (dualEdge ? (isInv ? selFall : selRise)
                                       : (isInv ? selRise : selFall));
  assign endEdge   = isExt & (isInv ? selRise : selFall);

  always_comb begin
    unique case (stb.len)
      LEN_PWR: lenVal = CNT_W'(PWR_LEN - 1);
      LEN_ACQ: lenVal = CNT_W'(ACQ_LEN - 1);
      LEN_TRK: lenVal = CNT_W'(TRK_LEN - 1);
      default: lenVal = CNT_W'(CONV_LEN - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            cnt <= '0;
    else if (stb.load)    cnt <= lenVal;
    else if (cnt != '0)   cnt <= cnt - 1'b1;

  assign cntZero = (cnt == '0);

  // R3/R2: a closing edge and an opening edge of the same line never coincide
  assert_edge_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    dualEdge |-> !(startEdge && endEdge));
endmodule

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int ACQ_LEN  = 3,
  parameter int TRK_LEN  = 11,
  parameter int CONV_LEN = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] srcSel,
  input  logic       dualEdge,
  input  logic       autoShutdown,
  input  logic       startWr,
  input  logic       startEdge,
  input  logic       endEdge,
  input  logic       cntZero,
  output ctrlStb_t   stb,
  output phase_t     ph,
  output logic       doneR
);
  localparam int RUN_MAX = (TRK_LEN > CONV_LEN) ? TRK_LEN : CONV_LEN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1) + 1;

  phase_t nxt;
  logic   doneNxt;

  always_comb begin
    nxt     = ph;
    stb     = '{load: 1'b0, len: LEN_CNV};
    doneNxt = 1'b0;
    unique case (ph)
      PH_IDLE: begin
        if (srcSel == SRC_CONT) begin
          stb.load = 1'b1;
          if (autoShutdown) begin nxt = PH_PWR; stb.len = LEN_PWR; end
          else              begin nxt = PH_TRK; stb.len = LEN_ACQ; end
        end else if ((srcSel == SRC_SWST && startWr) || (!dualEdge && startEdge)) begin
          stb.load = 1'b1;
          if (autoShutdown) begin nxt = PH_TRK; stb.len = LEN_TRK; end
          else              begin nxt = PH_CNV; stb.len = LEN_CNV; end
        end else if (dualEdge && startEdge) begin
          nxt = PH_USR;
        end
      end
      PH_PWR: if (cntZero) begin
        nxt = PH_TRK; stb.load = 1'b1; stb.len = LEN_ACQ;
      end
      PH_TRK: if (cntZero) begin
        nxt = PH_CNV; stb.load = 1'b1; stb.len = LEN_CNV;
      end
      PH_USR: if (endEdge) begin
        nxt = PH_CNV; stb.load = 1'b1; stb.len = LEN_CNV;
      end
      PH_CNV: if (cntZero) begin
        doneNxt = 1'b1;
        if (srcSel == SRC_CONT) begin
          nxt = PH_TRK; stb.load = 1'b1; stb.len = LEN_ACQ;
        end else begin
          nxt = PH_IDLE;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      ph    <= PH_IDLE;
      doneR <= 1'b0;
    end else begin
      ph    <= nxt;
      doneR <= doneNxt;
    end

  // Run-length shadows for the checks below
  logic [RUN_W-1:0] cnvRun, trkRun;
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      cnvRun <= '0;
      trkRun <= '0;
    end else begin
      cnvRun <= (ph == PH_CNV) ? cnvRun + 1'b1 : '0;
      trkRun <= (ph == PH_TRK) ? trkRun + 1'b1 : '0;
    end

  assert_conv_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_CNV && nxt != PH_CNV) |-> cnvRun == RUN_W'(CONV_LEN - 1));

  assert_trk_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ph == PH_TRK && nxt == PH_CNV) |->
      (trkRun == RUN_W'(ACQ_LEN - 1) || trkRun == RUN_W'(TRK_LEN - 1)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  assert_done_after_conv_R9: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> ($past(ph) == PH_CNV && ph != PH_CNV));
endmodule

// File: rtl/adcTrigSeq.sv
module adcTrigSeq
  import adcSeqPkg::*;
#(
  parameter int NUM_TMR     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int PWR_LEN     = 8,
  parameter int ACQ_LEN     = 3,
  parameter int TRK_LEN     = 11,
  parameter int CONV_LEN    = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         srcSel,
  input  logic               dualEdge,
  input  logic               autoShutdown,
  input  logic [NUM_TMR-1:0] tmrIn,
  input  logic               ctlIn,
  input  logic               startWr,
  output logic               pwrEn,
  output logic               trackOn,
  output logic               convActive,
  output logic               busy,
  output logic               done
);
  ctrlStb_t stb;
  phase_t   ph;
  logic     startEdge, endEdge, cntZero;

  adcSeqPath #(
    .NUM_TMR(NUM_TMR), .SYNC_STAGES(SYNC_STAGES), .PWR_LEN(PWR_LEN),
    .ACQ_LEN(ACQ_LEN), .TRK_LEN(TRK_LEN), .CONV_LEN(CONV_LEN)
  ) uPath (
    .clk(clk), .rstN(rstN), .tmrIn(tmrIn), .ctlIn(ctlIn), .srcSel(srcSel),
    .dualEdge(dualEdge), .stb(stb), .startEdge(startEdge), .endEdge(endEdge),
    .cntZero(cntZero)
  );

  adcSeqCtrl #(
    .ACQ_LEN(ACQ_LEN), .TRK_LEN(TRK_LEN), .CONV_LEN(CONV_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .dualEdge(dualEdge),
    .autoShutdown(autoShutdown), .startWr(startWr), .startEdge(startEdge),
    .endEdge(endEdge), .cntZero(cntZero), .stb(stb), .ph(ph), .doneR(done)
  );

  assign busy       = (ph != PH_IDLE);
  assign trackOn    = (ph == PH_TRK) || (ph == PH_USR);
  assign convActive = (ph == PH_CNV);
  assign pwrEn      = autoShutdown ? busy : 1'b1;

  assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

// File: tb/adcTrigSeq_test.sv
module adcTrigSeq_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] srcSel = 3'b011;
  logic       dualEdge = 1'b0;
  logic       autoShutdown = 1'b1;
  logic [2:0] tmrIn = 3'b000;
  logic       ctlIn = 1'b0;
  logic       startWr = 1'b0;
  logic       pwrEn, trackOn, convActive, busy, done;

  int    checks = 0;
  int    failures = 0;
  string curReq = "R9";

  always #4 clk = ~clk;

  adcTrigSeq uut (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .dualEdge(dualEdge),
    .autoShutdown(autoShutdown), .tmrIn(tmrIn), .ctlIn(ctlIn), .startWr(startWr),
    .pwrEn(pwrEn), .trackOn(trackOn), .convActive(convActive), .busy(busy), .done(done)
  );

  // Behavioural reference: phase 0 idle, 1 power-up, 2 timed track, 3 user track, 4 convert
  int mPh = 0, mLeft = 0;
  bit mDone = 0;
  bit [3:0] h1 = 0, h2 = 0, h3 = 0;

  always @(posedge clk) begin
    bit [3:0] rs, fs;
    bit ext, inv, sr, sf, stE, enE, autoStart;
    if (!rstN) begin
      mPh = 0; mLeft = 0; mDone = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      rs = h2 & ~h3; fs = ~h2 & h3;
      ext = 0; inv = 0; sr = 0; sf = 0;
      case (srcSel)
        3'b000, 3'b001, 3'b010: begin ext = 1; sr = rs[srcSel[1:0]]; sf = fs[srcSel[1:0]]; end
        3'b100: begin ext = 1; sr = rs[3]; sf = fs[3]; end
        3'b101: begin ext = 1; inv = 1; sr = rs[3]; sf = fs[3]; end
        default: ;
      endcase
      stE = ext && (dualEdge ? (inv ? sf : sr) : (inv ? sr : sf));
      enE = ext && (inv ? sr : sf);
      autoStart = (srcSel == 3'b111 && startWr) || (!dualEdge && stE);
      mDone = 0;
      case (mPh)
        0: if (srcSel == 3'b110) begin
             if (autoShutdown) begin mPh = 1; mLeft = 8; end
             else begin mPh = 2; mLeft = 3; end
           end else if (autoStart) begin
             if (autoShutdown) begin mPh = 2; mLeft = 11; end
             else begin mPh = 4; mLeft = 13; end
           end else if (dualEdge && stE) mPh = 3;
        1: begin mLeft--; if (mLeft == 0) begin mPh = 2; mLeft = 3; end end
        2: begin mLeft--; if (mLeft == 0) begin mPh = 4; mLeft = 13; end end
        3: if (enE) begin mPh = 4; mLeft = 13; end
        default: begin
          mLeft--;
          if (mLeft == 0) begin
            mDone = 1;
            if (srcSel == 3'b110) begin mPh = 2; mLeft = 3; end
            else mPh = 0;
          end
        end
      endcase
      h3 = h2; h2 = h1; h1 = {ctlIn, tmrIn};
    end
  end

  // Per-cycle comparison of all outputs against the model
  always @(negedge clk) begin
    bit mBusy;
    logic [4:0] act, exp;
    #2;
    mBusy = (mPh != 0);
    exp = {autoShutdown ? mBusy : 1'b1, (mPh == 2 || mPh == 3), (mPh == 4), mBusy, mDone};
    act = {pwrEn, trackOn, convActive, busy, done};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle compare {pwrEn,trackOn,convActive,busy,done} actual=%b expected=%b",
               curReq, act, exp);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic runToIdle(output int trk, output int cnv, output int dn);
    bit seen = 0;
    trk = 0; cnv = 0; dn = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #2;
      if (trackOn) trk++;
      if (convActive) cnv++;
      if (done) dn++;
      if (busy) seen = 1;
      else if (seen) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int trk, cnv, dn, firstTrk, d1, d2;
    step(5);
    rstN = 1'b1;
    step(2);
    // Reset state, R9 / R12
    #1;
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R12 pwrEn idle with autoShutdown", pwrEn, 0);
    step(1);

    // R2: dual-edge, control pin
    curReq = "R2"; dualEdge = 1; srcSel = 3'b100;
    step(2);
    fork
      runToIdle(trk, cnv, dn);
      begin ctlIn = 1; step(10); ctlIn = 0; end
    join
    chk("R2 track length", trk, 10);
    chk("R6 conversion length", cnv, 13);
    chk("R9 done count", dn, 1);
    step(4);

    // R1: timer 1 in dual-edge while timer 0 toggles
    curReq = "R1"; srcSel = 3'b001;
    step(1);
    fork
      runToIdle(trk, cnv, dn);
      begin tmrIn[1] = 1; tmrIn[0] = 1; step(5); tmrIn[1] = 0; end
    join
    chk("R1 timer1 track length", trk, 5);
    tmrIn[0] = 0; step(6);
    chk("R1 unselected timer0 ignored", busy, 0);

    // R3: dual-edge, inverted pin
    curReq = "R3"; srcSel = 3'b101;
    ctlIn = 1; step(6);
    chk("R3 rising edge does not open track", busy, 0);
    fork
      runToIdle(trk, cnv, dn);
      begin ctlIn = 0; step(7); ctlIn = 1; end
    join
    chk("R3 track length", trk, 7);
    step(4);

    // R4/R5: single-edge timer 0 with autoShutdown
    curReq = "R5"; dualEdge = 0; srcSel = 3'b000;
    tmrIn[0] = 1; step(6);
    chk("R4 rising edge ignored in single-edge", busy, 0);
    fork
      runToIdle(trk, cnv, dn);
      begin tmrIn[0] = 0; end
    join
    chk("R5 timed track length", trk, 11);
    chk("R6 conversion length", cnv, 13);
    chk("R9 single done pulse", dn, 1);
    step(3);

    // R5/R12: autoShutdown off, timer 2
    curReq = "R12"; autoShutdown = 0; srcSel = 3'b010;
    step(1);
    chk("R12 pwrEn held with autoShutdown off", pwrEn, 1);
    tmrIn[2] = 1; step(6);
    fork
      runToIdle(trk, cnv, dn);
      begin tmrIn[2] = 0; end
    join
    chk("R5 no track without autoShutdown", trk, 0);
    chk("R6 conversion length", cnv, 13);
    chk("R12 pwrEn after conversion", pwrEn, 1);
    autoShutdown = 1; step(3);

    // R4: single-edge inverted pin (ctlIn is 1 here)
    curReq = "R4"; srcSel = 3'b101;
    ctlIn = 0; step(6);
    chk("R4 falling edge ignored for inverted single-edge", busy, 0);
    fork
      runToIdle(trk, cnv, dn);
      begin ctlIn = 1; end
    join
    chk("R4 inverted rising edge starts timed track", trk, 11);
    step(3);

    // R8: software start, both trigger styles
    curReq = "R8"; srcSel = 3'b111;
    for (int d = 1; d >= 0; d--) begin
      dualEdge = d[0];
      step(1);
      fork
        runToIdle(trk, cnv, dn);
        begin startWr = 1; step(1); startWr = 0; end
      join
      chk("R8 software start track length", trk, 11);
      chk("R8 software start done", dn, 1);
      step(3);
    end
    srcSel = 3'b000; startWr = 1; step(1); startWr = 0; step(6);
    chk("R8 startWr ignored for other source", busy, 0);

    // R10: edges during busy ignored (ctlIn is 1)
    curReq = "R10"; srcSel = 3'b100; step(2);
    fork
      runToIdle(trk, cnv, dn);
      begin ctlIn = 0; step(15); ctlIn = 1; step(3); ctlIn = 0; step(3); ctlIn = 1; end
    join
    chk("R10 single conversion despite edges", dn, 1);
    step(8);
    chk("R10 idle afterwards", busy, 0);

    // R11: synchronizer latency (ctlIn is 1, falling edge starts)
    curReq = "R11";
    ctlIn = 0;
    @(negedge clk); @(negedge clk); #2;
    chk("R11 busy still low after two edges", busy, 0);
    @(negedge clk); #2;
    chk("R11 busy high after third edge", busy, 1);
    runToIdle(trk, cnv, dn);
    step(3);

    // R7/R13: continuous with autoShutdown
    curReq = "R7"; srcSel = 3'b110;
    firstTrk = -1; d1 = -1; d2 = -1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #2;
      if (trackOn && firstTrk < 0) firstTrk = i;
      if (done) begin if (d1 < 0) d1 = i; else if (d2 < 0) d2 = i; end
    end
    chk("R7 power-up wait", firstTrk, 8);
    chk("R7 first done position", d1, 24);
    chk("R7 repeat period", d2 - d1, 16);
    curReq = "R13"; #1; srcSel = 3'b011;
    runToIdle(trk, cnv, dn);
    chk("R13 finishing conversion done", dn, 1);
    step(20);
    chk("R13 stays idle", busy, 0);

    // R7: continuous without autoShutdown starts with track at once
    curReq = "R7"; autoShutdown = 0; step(1); srcSel = 3'b110;
    @(negedge clk); #2;
    chk("R7 immediate track without power-up", trackOn, 1);
    #1; srcSel = 3'b011;
    runToIdle(trk, cnv, dn);
    chk("R7 track then one conversion", cnv, 13);
    step(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule